// File: doc/BRIEF.md
# Coprocessor Interrupt Status and Cause Unit

This block keeps the two control registers that a system coprocessor uses to decide whether the core takes a hardware interrupt: a status register and a cause register. It combines the global enable, the exception and error levels, and a debug-mode input to gate interrupt requests. Behind that gate it compares the pending field of the cause register with the mask field of the status register. The comparison is either a per-line AND or an unsigned level comparison, selected by a configuration input that reports whether an external vectoring controller is fitted.

Software writes reach each register through a write mask. For status the mask is a parameter. For cause it is fixed and covers only the software interrupt bits, two control bits and, when the revision-2 feature input is high, the count-disable bit. Six external hardware lines are sampled into the upper pending bits on every clock. The block drives two software interrupt lines from the writable pending bits. It gives the count/compare timer one-cycle stop and restart pulses when the count-disable bit changes. It also reports the effective privilege mode.

Top module: `cp_irq_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it, status reads 0x0000_0004 (error level set, enable clear), cause reads 0, and irq_req_o, swi_o, cnt_stop_o and cnt_start_o are all 0.
- R2: irq_req_o is 0 whenever status bit 0 (enable) is 0, status bit 1 (exception level) is 1, status bit 2 (error level) is 1, or dbg_mode_i is 1.
- R3: With cfg_vec_mode_i = 0 and the gate of R2 open, irq_req_o is 1 exactly when cause[15:8] AND status[15:8] is nonzero.
- R4: With cfg_vec_mode_i = 1 and the gate open, irq_req_o is 1 exactly when cause[15:8], read as an unsigned number, is strictly greater than status[15:8]; equal values give 0.
- R5: A cause write updates only bits 23, 22, 9 and 8, plus bit 27 when cfg_rev2_i is 1. All other written bits are ignored. The write takes effect at the clock edge where cause_we_i is sampled high.
- R6: cnt_stop_o is a one-cycle pulse in the cycle after cause bit 27 changes from 0 to 1. cnt_start_o is a one-cycle pulse in the cycle after it changes from 1 to 0. The two are never high together.
- R7: swi_o[1:0] always equals cause[9:8], so each software line changes in the same cycle as its cause bit.
- R8: A status write changes only the bits set in parameter STAT_WMASK (default 0xF040_FF1F). Every other status bit keeps its value.
- R9: cause[15:10] holds hw_irq_i[5:0] as sampled at the previous clock edge, on every cycle, whatever a cause write carries in those bits.
- R10: priv_o equals status[4:3] when status bit 1, status bit 2 and dbg_mode_i are all 0, and is 0 (kernel) otherwise. The encodings are kernel 0, supervisor 1 and user 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_vec_mode_i | input | 1 | 1 selects the level comparison used with an external vectoring controller |
| cfg_rev2_i | input | 1 | 1 makes cause bit 27 software writable |
| dbg_mode_i | input | 1 | Debug mode active: blocks interrupts and forces kernel mode |
| hw_irq_i | input | 6 | External hardware interrupt lines |
| stat_we_i | input | 1 | Status register write strobe |
| cause_we_i | input | 1 | Cause register write strobe |
| wr_data_i | input | 32 | Write data for either register |
| status_o | output | 32 | Current status register |
| cause_o | output | 32 | Current cause register |
| irq_req_o | output | 1 | Hardware interrupt request |
| priv_o | output | 2 | Effective privilege mode |
| swi_o | output | 2 | Software interrupt lines |
| cnt_stop_o | output | 1 | Pulse: stop the count timer |
| cnt_start_o | output | 1 | Pulse: restart the count timer |

## Verification
A corrupted status or cause bit appears on status_o or cause_o in the cycle after the edge that stored it. Through the decision logic it usually also shows on irq_req_o or priv_o in that same cycle. A wrong hardware sample is visible in cause[15:10] one edge after the line changed. A missed or doubled count pulse shows only in the one cycle after a write to bit 27, so the bench compares the pulses on every cycle rather than only after writes. In level mode the equal-value case is the one that separates the strict comparison from a greater-or-equal one, so it is driven on purpose.

// File: rtl/cp_irq_pkg.sv
package cp_irq_pkg;
   // status field positions
   localparam int unsigned ST_IE     = 0;
   localparam int unsigned ST_EXL    = 1;
   localparam int unsigned ST_ERL    = 2;
   localparam int unsigned ST_KSU_LO = 3;
   localparam int unsigned ST_IM_LO  = 8;
   // cause field positions
   localparam int unsigned CA_IP_LO  = 8;
   localparam int unsigned CA_WP     = 22;
   localparam int unsigned CA_IV     = 23;
   localparam int unsigned CA_DC     = 27;

   typedef enum logic [1:0] {
      PRIV_KERNEL = 2'd0,
      PRIV_SUPER  = 2'd1,
      PRIV_USER   = 2'd2,
      PRIV_RSVD   = 2'd3
   } priv_e;
endpackage

// File: rtl/cp_status_reg.sv
module cp_status_reg #(
   parameter int unsigned       REG_W  = 32,
   parameter logic [REG_W-1:0]  WMASK  = '1,
   parameter logic [REG_W-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] q
);
   logic [REG_W-1:0] nxt;

   always_comb begin
      nxt = q;
      if (wr_en) nxt = (q & ~WMASK) | (wr_data & WMASK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= nxt;
   end
endmodule

// File: rtl/cp_cause_reg.sv
module cp_cause_reg
   import cp_irq_pkg::*;
#(
   parameter int unsigned REG_W    = 32,
   parameter int unsigned HW_LINES = 6,
   parameter int unsigned SW_LINES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [REG_W-1:0]    wr_data,
   input  logic                rev2_en,
   input  logic [HW_LINES-1:0] hw_irq,
   output logic [REG_W-1:0]    q,
   output logic [SW_LINES-1:0] swi,
   output logic                cnt_stop,
   output logic                cnt_start
);
   localparam int unsigned HW_LO = CA_IP_LO + SW_LINES;
   localparam logic [REG_W-1:0] ONE = REG_W'(1);
   localparam logic [REG_W-1:0] SW_FIELD = ((ONE << SW_LINES) - ONE) << CA_IP_LO;
   localparam logic [REG_W-1:0] BASE_MASK = (ONE << CA_IV) | (ONE << CA_WP) | SW_FIELD;
   localparam logic [REG_W-1:0] DC_BIT = ONE << CA_DC;

   logic [REG_W-1:0] wmask;
   logic [REG_W-1:0] nxt;

   always_comb begin
      wmask = BASE_MASK | (rev2_en ? DC_BIT : '0);
      nxt   = q;
      if (wr_en) nxt = (q & ~wmask) | (wr_data & wmask);
      nxt[HW_LO +: HW_LINES] = hw_irq;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q         <= '0;
         cnt_stop  <= 1'b0;
         cnt_start <= 1'b0;
      end else begin
         q         <= nxt;
         cnt_stop  <= ~q[CA_DC] &  nxt[CA_DC];
         cnt_start <=  q[CA_DC] & ~nxt[CA_DC];
      end
   end

   assign swi = q[CA_IP_LO +: SW_LINES];
endmodule

// File: rtl/cp_irq_decide.sv
module cp_irq_decide #(
   parameter int unsigned IP_W        = 8,
   parameter bit          VEC_SUPPORT = 1'b1
) (
   input  logic            gate_open,
   input  logic            vec_mode,
   input  logic [IP_W-1:0] pend,
   input  logic [IP_W-1:0] mask,
   output logic            req
);
   logic hit_and;
   assign hit_and = |(pend & mask);

   generate
      if (VEC_SUPPORT) begin : g_vec
         logic hit_lvl;
         assign hit_lvl = (pend > mask);
         assign req = gate_open & (vec_mode ? hit_lvl : hit_and);
      end else begin : g_flat
         logic unused_vec;
         assign unused_vec = vec_mode;
         assign req = gate_open & hit_and;
      end
   endgenerate
endmodule

// File: rtl/cp_priv_decode.sv
module cp_priv_decode
   import cp_irq_pkg::*;
(
   input  logic [1:0] ksu,
   input  logic       exl,
   input  logic       erl,
   input  logic       dbg,
   output priv_e      priv
);
   always_comb begin
      if (exl || erl || dbg) priv = PRIV_KERNEL;
      else                   priv = priv_e'(ksu);
   end
endmodule

// File: rtl/cp_irq_ctrl.sv
module cp_irq_ctrl
   import cp_irq_pkg::*;
#(
   parameter int unsigned       REG_W       = 32,
   parameter int unsigned       HW_LINES    = 6,
   parameter int unsigned       SW_LINES    = 2,
   parameter logic [REG_W-1:0]  STAT_WMASK  = 32'hF040_FF1F,
   parameter logic [REG_W-1:0]  STAT_RST    = 32'h0000_0004,
   parameter bit                VEC_SUPPORT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_vec_mode_i,
   input  logic                cfg_rev2_i,
   input  logic                dbg_mode_i,
   input  logic [HW_LINES-1:0] hw_irq_i,
   input  logic                stat_we_i,
   input  logic                cause_we_i,
   input  logic [REG_W-1:0]    wr_data_i,
   output logic [REG_W-1:0]    status_o,
   output logic [REG_W-1:0]    cause_o,
   output logic                irq_req_o,
   output logic [1:0]          priv_o,
   output logic [SW_LINES-1:0] swi_o,
   output logic                cnt_stop_o,
   output logic                cnt_start_o
);
   localparam int unsigned IP_W = HW_LINES + SW_LINES;

   generate
      if (IP_W != 8) begin : g_bad_ip
         $error("pending field must be 8 bits wide");
      end
      if (REG_W < 28) begin : g_bad_w
         $error("register width too small for cause bit 27");
      end
   endgenerate

   logic  gate_open;
   priv_e priv;

   cp_status_reg #(
      .REG_W   (REG_W),
      .WMASK   (STAT_WMASK),
      .RST_VAL (STAT_RST)
   ) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (stat_we_i),
      .wr_data (wr_data_i),
      .q       (status_o)
   );

   cp_cause_reg #(
      .REG_W    (REG_W),
      .HW_LINES (HW_LINES),
      .SW_LINES (SW_LINES)
   ) u_cause (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cause_we_i),
      .wr_data   (wr_data_i),
      .rev2_en   (cfg_rev2_i),
      .hw_irq    (hw_irq_i),
      .q         (cause_o),
      .swi       (swi_o),
      .cnt_stop  (cnt_stop_o),
      .cnt_start (cnt_start_o)
   );

   assign gate_open = status_o[ST_IE] & ~status_o[ST_EXL] & ~status_o[ST_ERL] & ~dbg_mode_i;

   cp_irq_decide #(
      .IP_W        (IP_W),
      .VEC_SUPPORT (VEC_SUPPORT)
   ) u_decide (
      .gate_open (gate_open),
      .vec_mode  (cfg_vec_mode_i),
      .pend      (cause_o[CA_IP_LO +: IP_W]),
      .mask      (status_o[ST_IM_LO +: IP_W]),
      .req       (irq_req_o)
   );

   cp_priv_decode u_priv (
      .ksu  (status_o[ST_KSU_LO +: 2]),
      .exl  (status_o[ST_EXL]),
      .erl  (status_o[ST_ERL]),
      .dbg  (dbg_mode_i),
      .priv (priv)
   );

   assign priv_o = priv;
endmodule

// File: rtl/cp_irq_ctrl_chk.sv
module cp_irq_ctrl_chk #(
   parameter int unsigned      REG_W      = 32,
   parameter int unsigned      HW_LINES   = 6,
   parameter int unsigned      SW_LINES   = 2,
   parameter logic [REG_W-1:0] STAT_WMASK = 32'hF040_FF1F
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_rev2_i,
   input logic                dbg_mode_i,
   input logic [HW_LINES-1:0] hw_irq_i,
   input logic                cause_we_i,
   input logic [REG_W-1:0]    status_o,
   input logic [REG_W-1:0]    cause_o,
   input logic                irq_req_o,
   input logic [1:0]          priv_o,
   input logic [SW_LINES-1:0] swi_o,
   input logic                cnt_stop_o,
   input logic                cnt_start_o
);
   localparam logic [REG_W-1:0] SW_HOLD = REG_W'(32'h08C0_0300);

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_o[0] || status_o[1] || status_o[2] || dbg_mode_i) |-> !irq_req_o); // R2
   AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cause_we_i |=> ((cause_o & SW_HOLD) == ($past(cause_o) & SW_HOLD))); // R5
   AST_DC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_we_i && !cfg_rev2_i) |=> (cause_o[27] == $past(cause_o[27]))); // R5
   AST_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_stop_o |-> (cause_o[27] && !$past(cause_o[27]))); // R6
   AST_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_start_o |-> (!cause_o[27] && $past(cause_o[27]))); // R6
   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cnt_stop_o && cnt_start_o)); // R6
   AST_SWI_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      swi_o == cause_o[8 +: SW_LINES]); // R7
   AST_STAT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((status_o ^ $past(status_o)) & ~STAT_WMASK) == '0)); // R8
   AST_HW_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cause_o[8+SW_LINES +: HW_LINES] == $past(hw_irq_i))); // R9
   AST_PRIV_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[1] || status_o[2] || dbg_mode_i) |-> (priv_o == 2'd0)); // R10
endmodule

bind cp_irq_ctrl cp_irq_ctrl_chk #(
   .REG_W      (REG_W),
   .HW_LINES   (HW_LINES),
   .SW_LINES   (SW_LINES),
   .STAT_WMASK (STAT_WMASK)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_rev2_i  (cfg_rev2_i),
   .dbg_mode_i  (dbg_mode_i),
   .hw_irq_i    (hw_irq_i),
   .cause_we_i  (cause_we_i),
   .status_o    (status_o),
   .cause_o     (cause_o),
   .irq_req_o   (irq_req_o),
   .priv_o      (priv_o),
   .swi_o       (swi_o),
   .cnt_stop_o  (cnt_stop_o),
   .cnt_start_o (cnt_start_o)
);

// File: tb/cp_irq_ctrl_test.sv
module cp_irq_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] SMASK = 32'hF040_FF1F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vec = 1'b0, rev2 = 1'b0, dbg = 1'b0;
   logic [5:0]  hw = '0;
   logic        swe = 1'b0, cwe = 1'b0;
   logic [31:0] wd = '0;
   logic [31:0] status_o, cause_o;
   logic        irq_req_o, cnt_stop_o, cnt_start_o;
   logic [1:0]  priv_o, swi_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [31:0] m_st, m_ca;
   logic        m_stop, m_start;

   always #(CLK_PERIOD/2) clk = ~clk;

   cp_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cfg_vec_mode_i(vec), .cfg_rev2_i(rev2),
      .dbg_mode_i(dbg), .hw_irq_i(hw), .stat_we_i(swe), .cause_we_i(cwe),
      .wr_data_i(wd), .status_o(status_o), .cause_o(cause_o),
      .irq_req_o(irq_req_o), .priv_o(priv_o), .swi_o(swi_o),
      .cnt_stop_o(cnt_stop_o), .cnt_start_o(cnt_start_o)
   );

   function automatic logic exp_irq(logic [31:0] st, logic [31:0] ca, logic v, logic d);
      if (!st[0] || st[1] || st[2] || d) return 1'b0;
      if (v) return ca[15:8] > st[15:8];
      return |(ca[15:8] & st[15:8]);
   endfunction

   function automatic logic [1:0] exp_priv(logic [31:0] st, logic d);
      if (st[1] || st[2] || d) return 2'd0;
      return st[4:3];
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      logic e;
      string t;
      e = exp_irq(m_st, m_ca, vec, dbg);
      if (!m_st[0] || m_st[1] || m_st[2] || dbg) t = "R2 irq gated";
      else if (vec) t = "R4 level compare";
      else t = "R3 mask and";
      chk(status_o === m_st, "R8 status", status_o, m_st);
      chk(cause_o === m_ca, "R5/R9 cause", cause_o, m_ca);
      chk(irq_req_o === e, t, 32'(irq_req_o), 32'(e));
      chk(priv_o === exp_priv(m_st, dbg), "R10 priv", 32'(priv_o), 32'(exp_priv(m_st, dbg)));
      chk(swi_o === m_ca[9:8], "R7 swi", 32'(swi_o), 32'(m_ca[9:8]));
      chk(cnt_stop_o === m_stop, "R6 stop pulse", 32'(cnt_stop_o), 32'(m_stop));
      chk(cnt_start_o === m_start, "R6 start pulse", 32'(cnt_start_o), 32'(m_start));
   endtask

   // one clock: model follows the edge, compare at the falling edge
   task automatic step();
      logic [31:0] old, wm;
      @(posedge clk);
      if (swe) m_st = (m_st & ~SMASK) | (wd & SMASK);
      old = m_ca;
      wm = 32'h00C0_0300 | (rev2 ? 32'h0800_0000 : 32'h0);
      if (cwe) m_ca = (m_ca & ~wm) | (wd & wm);
      m_ca[15:10] = hw;
      m_stop  = !old[27] && m_ca[27];
      m_start = old[27] && !m_ca[27];
      @(negedge clk);
      check_all();
      swe = 1'b0;
      cwe = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd7315));
      m_st = 32'h0000_0004; m_ca = '0; m_stop = 1'b0; m_start = 1'b0;
      repeat (3) @(negedge clk);
      check_all(); // R1 during reset
      rst_n = 1'b1;
      step();      // R1 first cycle after reset
      chk(status_o === 32'h4 && cause_o === 32'h0, "R1 reset state", status_o, 32'h4);

      // directed: level mode, equal values must not request
      vec = 1'b1; wd = 32'h0000_2401; swe = 1'b1; hw = 6'b001001; step();
      step();
      chk(irq_req_o === 1'b0, "R4 equal levels", 32'(irq_req_o), 32'h0);
      wd = 32'h0000_0100; cwe = 1'b1; step();
      chk(irq_req_o === 1'b1, "R4 pending above mask", 32'(irq_req_o), 32'h1);
      dbg = 1'b1; step();
      chk(irq_req_o === 1'b0, "R2 debug blocks", 32'(irq_req_o), 32'h0);
      dbg = 1'b0; vec = 1'b0; step();

      // directed: count-disable bit
      rev2 = 1'b0; wd = 32'h0800_0000; cwe = 1'b1; step();
      chk(cause_o[27] === 1'b0 && cnt_stop_o === 1'b0, "R5 bit27 locked", cause_o, 32'h0);
      rev2 = 1'b1; wd = 32'h0800_0000; cwe = 1'b1; step();
      chk(cnt_stop_o === 1'b1, "R6 stop on set", 32'(cnt_stop_o), 32'h1);
      step();
      chk(cnt_stop_o === 1'b0, "R6 stop one cycle", 32'(cnt_stop_o), 32'h0);
      wd = 32'h0; cwe = 1'b1; step();
      chk(cnt_start_o === 1'b1, "R6 start on clear", 32'(cnt_start_o), 32'h1);

      // directed: hw bits not writable
      hw = 6'h00; wd = 32'h0000_FC00; cwe = 1'b1; step();
      chk(cause_o[15:10] === 6'h00, "R9 hw field ignores writes", cause_o, 32'h0);

      // directed: privilege
      wd = 32'h0000_0011; swe = 1'b1; step();
      chk(priv_o === 2'd2, "R10 user mode", 32'(priv_o), 32'h2);
      dbg = 1'b1; step();
      chk(priv_o === 2'd0, "R10 debug forces kernel", 32'(priv_o), 32'h0);
      dbg = 1'b0;

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         if (i % 200 == 0) vec = 1'($urandom);
         rev2 = ($urandom % 4) != 0;
         dbg  = ($urandom % 10) == 0;
         hw   = 6'($urandom);
         wd   = $urandom;
         swe  = ($urandom % 5) == 0;
         if (swe) begin
            if ($urandom % 4 != 0) wd[2:1] = 2'b00;
            wd[0] = ($urandom % 4) != 0;
         end
         cwe  = ($urandom % 3) == 0;
         step();
      end
      done = 1'b1;
      finish_run();
   end
endmodule